// File: doc/BRIEF.md
# CPU Bus Cycle Controller

This block connects an 8-bit processor that multiplexes address, control and data on one set of lines to a shared system bus. The processor presents its transfer in three states. Each state comes with a one-cycle strobe. The first strobe carries the low address byte. The second carries the upper six address bits together with a two-bit cycle type in bits 7:6. The third carries write data, or marks the window in which read data must reach the processor. The block holds these pieces in buffer registers and presents a 14-bit address and an 8-bit write datum to the bus.

Bus commands do not start when the second strobe arrives. They start at the next memory-cycle boundary, given as a one-cycle pulse `mem_edge`, and they end at the first boundary after the third state. Reads whose address falls inside a local ROM window are served from a private ROM port. For these the bus signals stay idle, so the bus is free for other masters. I/O command cycles put the address on the bus and assert a separate I/O strobe, but the memory read command stays low.

Top module: `cpu_bus_cycle_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every command output is low, and `bus_addr`, `bus_dout` and `cpu_din` are zero.
- R2: The byte given with `t1_stb` becomes `bus_addr[7:0]`, and bits 5:0 of the byte given with `t2_stb` become `bus_addr[13:8]` while `addr_en` is high. `bus_addr` is zero while `addr_en` is low.
- R3: Cycle type is bits 7:6 of the `t2_stb` byte: 00 instruction fetch, 01 data read, 10 I/O command, 11 write.
- R4: No command output rises after `t2_stb` until a `mem_edge` pulse arrives. The command set then appears in the cycle after that pulse.
- R5: Once active, commands stay on through any `mem_edge` that comes before `t3_stb`. They drop in the cycle after the first `mem_edge` that follows `t3_stb`.
- R6: In a write cycle, `bus_req`, `addr_en` and `wr_cmd` are high. The byte given with `t3_stb` appears on `bus_dout` from the cycle after that strobe.
- R7: In a fetch or data read whose address bits 13:8 lie outside the ROM window, `bus_req`, `addr_en` and `rd_cmd` are high. `rd_strobe` is high in the cycle of `t3_stb`, and the `bus_din` value present then appears on `cpu_din` from the next cycle.
- R8: In a fetch or data read whose address bits 13:8 lie inside the ROM window (default 0 to 3), `rom_sel` is high and `cpu_din` follows `rom_din`. `bus_req`, `addr_en`, `rd_cmd` and `rd_strobe` all stay low.
- R9: In an I/O command cycle, `io_cmd`, `bus_req` and `addr_en` are high and `rd_cmd` stays low, whatever the address. `bus_din` is captured at `t3_stb` through `rd_strobe`.
- R10: Writes and I/O commands use the bus even when their address lies inside the ROM window.
- R11: At most one of `rd_cmd`, `wr_cmd` and `io_cmd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t1_stb | input | 1 | Processor first-state strobe |
| t2_stb | input | 1 | Processor second-state strobe |
| t3_stb | input | 1 | Processor third-state strobe |
| cpu_dout | input | 8 | Processor multiplexed output lines |
| mem_edge | input | 1 | Memory-cycle boundary pulse |
| bus_din | input | 8 | System bus read data |
| rom_din | input | 8 | Local ROM read data |
| bus_addr | output | 14 | Address driven to the bus |
| bus_dout | output | 8 | Write data driven to the bus |
| bus_req | output | 1 | Bus request |
| addr_en | output | 1 | Address enable |
| rd_cmd | output | 1 | Memory read command |
| wr_cmd | output | 1 | Memory write command |
| io_cmd | output | 1 | I/O command strobe |
| rd_strobe | output | 1 | Load strobe for the input data buffer |
| rom_sel | output | 1 | ROM window selected for the current read |
| cpu_din | output | 8 | Data returned to the processor |

## Verification
The bench runs each of the four cycle types through the full three-state sequence. The cases are a write addressed inside the ROM window, a data read outside it, a fetch inside it and an I/O command inside it. Pairing the same window with different cycle types shows whether the ROM suppression depends on cycle type as well as address. Checks made between the second strobe and the first boundary, and at an extra boundary placed before the third strobe, show whether commands are correctly aligned to memory-cycle edges rather than to processor states. Distinct values on `bus_din` and `rom_din` show which data source reached the processor.

// File: rtl/cpu_bus_cycle_pkg.sv
package cpu_bus_cycle_pkg;
   typedef enum logic [1:0] {
      CT_FETCH = 2'b00,
      CT_DREAD = 2'b01,
      CT_IOCMD = 2'b10,
      CT_WRITE = 2'b11
   } cyc_type_e;
endpackage

// File: rtl/cpu_bus_addr_capture.sv
module cpu_bus_addr_capture #(
   parameter int DW = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      t1_stb,
   input  logic                      t2_stb,
   input  logic                      t3_stb,
   input  logic [DW-1:0]             cpu_dout,
   output logic [DW-1:0]             addr_lo,
   output logic [DW-3:0]             addr_hi,
   output cpu_bus_cycle_pkg::cyc_type_e ctype,
   output logic [DW-1:0]             wdata
);
   import cpu_bus_cycle_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_lo <= '0;
         addr_hi <= '0;
         ctype   <= CT_FETCH;
         wdata   <= '0;
      end else begin
         if (t1_stb) addr_lo <= cpu_dout;
         if (t2_stb) begin
            addr_hi <= cpu_dout[DW-3:0];
            ctype   <= cyc_type_e'(cpu_dout[DW-1:DW-2]);
         end
         if (t3_stb && ctype == CT_WRITE) wdata <= cpu_dout;
      end
   end
endmodule

// File: rtl/cpu_bus_rom_window.sv
module cpu_bus_rom_window #(
   parameter int HW     = 6,
   parameter int ROM_LO = 0,
   parameter int ROM_HI = 3
) (
   input  logic [HW-1:0] addr_hi,
   output logic          hit
);
   localparam logic [HW-1:0] LO_V = HW'(ROM_LO);
   localparam logic [HW-1:0] HI_V = HW'(ROM_HI);

   if (ROM_LO > ROM_HI || ROM_HI >= (1 << HW)) begin : g_bad_window
      $error("ROM window bounds out of order or out of range");
   end

   if (ROM_LO == ROM_HI) begin : g_single
      assign hit = (addr_hi == LO_V);
   end else if (ROM_LO == 0) begin : g_from_zero
      assign hit = (addr_hi <= HI_V);
   end else begin : g_range
      assign hit = (addr_hi >= LO_V) && (addr_hi <= HI_V);
   end
endmodule

// File: rtl/cpu_bus_cycle_seq.sv
module cpu_bus_cycle_seq (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         t2_stb,
   input  logic                         t3_stb,
   input  logic                         mem_edge,
   input  cpu_bus_cycle_pkg::cyc_type_e ctype,
   output logic                         wr_ff,
   output logic                         rd_ff
);
   import cpu_bus_cycle_pkg::*;

   logic pend;
   logic t3_seen;
   logic active;

   assign active = wr_ff | rd_ff;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend    <= 1'b0;
         t3_seen <= 1'b0;
         wr_ff   <= 1'b0;
         rd_ff   <= 1'b0;
      end else begin
         if (t2_stb) pend <= 1'b1;
         if (t3_stb && (pend || active)) t3_seen <= 1'b1;
         if (mem_edge) begin
            if (active && t3_seen) begin
               wr_ff   <= 1'b0;
               rd_ff   <= 1'b0;
               t3_seen <= 1'b0;
            end else if (pend && !active) begin
               wr_ff <= (ctype == CT_WRITE);
               rd_ff <= (ctype != CT_WRITE);
               pend  <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/cpu_bus_cycle_ctrl.sv
module cpu_bus_cycle_ctrl #(
   parameter int DW     = 8,
   parameter int ROM_LO = 0,
   parameter int ROM_HI = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              t1_stb,
   input  logic              t2_stb,
   input  logic              t3_stb,
   input  logic [DW-1:0]     cpu_dout,
   input  logic              mem_edge,
   input  logic [DW-1:0]     bus_din,
   input  logic [DW-1:0]     rom_din,
   output logic [2*DW-3:0]   bus_addr,
   output logic [DW-1:0]     bus_dout,
   output logic              bus_req,
   output logic              addr_en,
   output logic              rd_cmd,
   output logic              wr_cmd,
   output logic              io_cmd,
   output logic              rd_strobe,
   output logic              rom_sel,
   output logic [DW-1:0]     cpu_din
);
   import cpu_bus_cycle_pkg::*;

   localparam int HW = DW - 2;
   localparam int AW = DW + HW;

   if (DW < 4) begin : g_bad_width
      $error("data width too small for a type field");
   end

   logic [DW-1:0] addr_lo;
   logic [HW-1:0] addr_hi;
   cyc_type_e     ctype;
   logic [DW-1:0] wdata;
   logic [DW-1:0] in_buf;
   logic          wr_ff, rd_ff, rom_hit, mem_read, bus_path;
   logic [AW-1:0] addr_full;

   cpu_bus_addr_capture #(.DW(DW)) u_cap (
      .clk(clk), .rst(rst), .t1_stb(t1_stb), .t2_stb(t2_stb),
      .t3_stb(t3_stb), .cpu_dout(cpu_dout), .addr_lo(addr_lo),
      .addr_hi(addr_hi), .ctype(ctype), .wdata(wdata)
   );

   cpu_bus_rom_window #(.HW(HW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_rom (
      .addr_hi(addr_hi), .hit(rom_hit)
   );

   cpu_bus_cycle_seq u_seq (
      .clk(clk), .rst(rst), .t2_stb(t2_stb), .t3_stb(t3_stb),
      .mem_edge(mem_edge), .ctype(ctype), .wr_ff(wr_ff), .rd_ff(rd_ff)
   );

   assign mem_read  = (ctype == CT_FETCH) || (ctype == CT_DREAD);
   assign rom_sel   = rd_ff && mem_read && rom_hit;
   assign bus_path  = wr_ff || (rd_ff && !rom_sel);
   assign addr_full = {addr_hi, addr_lo};

   assign bus_req   = bus_path;
   assign addr_en   = bus_path;
   assign rd_cmd    = rd_ff && mem_read && !rom_hit;
   assign wr_cmd    = wr_ff;
   assign io_cmd    = rd_ff && (ctype == CT_IOCMD);
   assign rd_strobe = rd_ff && !rom_sel && t3_stb;
   assign bus_addr  = addr_en ? addr_full : '0;
   assign bus_dout  = wr_cmd ? wdata : '0;
   assign cpu_din   = rom_sel ? rom_din : in_buf;

   always_ff @(posedge clk) begin
      if (rst) in_buf <= '0;
      else if (rd_strobe) in_buf <= bus_din;
   end
endmodule

// File: rtl/cpu_bus_cycle_chk.sv
module cpu_bus_cycle_chk (
   input logic clk,
   input logic rst,
   input logic t3_stb,
   input logic mem_edge,
   input logic bus_req,
   input logic addr_en,
   input logic rd_cmd,
   input logic wr_cmd,
   input logic io_cmd,
   input logic rd_strobe,
   input logic rom_sel
);
   // R8
   rom_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      rom_sel |-> (!bus_req && !addr_en && !rd_cmd && !rd_strobe));
   // R11
   one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_cmd, wr_cmd, io_cmd}));
   // R7
   rd_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
      rd_cmd |-> (bus_req && addr_en));
   // R9
   io_no_read_chk: assert property (@(posedge clk) disable iff (rst)
      io_cmd |-> (addr_en && !rd_cmd));
   // R4
   start_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(addr_en) |-> $past(mem_edge));
   // R5
   stop_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(addr_en) |-> $past(mem_edge));
   // R7
   strobe_in_t3_chk: assert property (@(posedge clk) disable iff (rst)
      rd_strobe |-> t3_stb);
endmodule

bind cpu_bus_cycle_ctrl cpu_bus_cycle_chk u_chk (
   .clk(clk), .rst(rst), .t3_stb(t3_stb), .mem_edge(mem_edge),
   .bus_req(bus_req), .addr_en(addr_en), .rd_cmd(rd_cmd),
   .wr_cmd(wr_cmd), .io_cmd(io_cmd), .rd_strobe(rd_strobe),
   .rom_sel(rom_sel)
);

// File: tb/cpu_bus_cycle_ctrl_bench.sv
module cpu_bus_cycle_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic t1_stb = 1'b0, t2_stb = 1'b0, t3_stb = 1'b0, mem_edge = 1'b0;
   logic [7:0] cpu_dout = '0, bus_din = '0, rom_din = '0;
   logic [13:0] bus_addr;
   logic [7:0] bus_dout, cpu_din;
   logic bus_req, addr_en, rd_cmd, wr_cmd, io_cmd, rd_strobe, rom_sel;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_bus_cycle_ctrl u_cpu_bus_cycle_ctrl (
      .clk(clk), .rst(rst), .t1_stb(t1_stb), .t2_stb(t2_stb),
      .t3_stb(t3_stb), .cpu_dout(cpu_dout), .mem_edge(mem_edge),
      .bus_din(bus_din), .rom_din(rom_din), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_req(bus_req), .addr_en(addr_en),
      .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .io_cmd(io_cmd),
      .rd_strobe(rd_strobe), .rom_sel(rom_sel), .cpu_din(cpu_din)
   );

   // command vector order: bus_req, addr_en, rd_cmd, wr_cmd, io_cmd, rom_sel
   function automatic logic [5:0] cmds();
      return {bus_req, addr_en, rd_cmd, wr_cmd, io_cmd, rom_sel};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse_t1(input logic [7:0] b);
      @(negedge clk); t1_stb = 1'b1; cpu_dout = b;
      @(negedge clk); t1_stb = 1'b0;
   endtask

   task automatic pulse_t2(input logic [7:0] b);
      @(negedge clk); t2_stb = 1'b1; cpu_dout = b;
      @(negedge clk); t2_stb = 1'b0;
   endtask

   task automatic pulse_edge();
      @(negedge clk); mem_edge = 1'b1;
      @(negedge clk); mem_edge = 1'b0;
   endtask

   // front half of a cycle: T1, T2, check idle before boundary, then boundary
   task automatic front(input logic [1:0] ty, input logic [13:0] a, input logic [5:0] exp_on);
      pulse_t1(a[7:0]);
      pulse_t2({ty, a[13:8]});
      @(negedge clk);
      chk("R4 idle before boundary", {26'd0, cmds()}, 32'd0);
      pulse_edge();
      chk("R4 commands after boundary", {26'd0, cmds()}, {26'd0, exp_on});
   endtask

   task automatic back(input string tag);
      pulse_edge();
      chk({tag, " R5 commands drop after T3 boundary"}, {26'd0, cmds()}, 32'd0);
      chk({tag, " R2 address released"}, {18'd0, bus_addr}, 32'd0);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk("R1 commands in reset", {26'd0, cmds(), rd_strobe}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 buses after reset", {bus_addr, bus_dout, cpu_din}, 32'd0);
   endtask

   task automatic test_write();
      // R10 R6: write to 0x0123, address inside ROM window, still on bus
      front(2'b11, 14'h0123, 6'b110100);
      chk("R2 R10 write address", {18'd0, bus_addr}, 32'h0123);
      pulse_edge();
      chk("R5 early boundary keeps write", {26'd0, cmds()}, 32'b110100);
      @(negedge clk); t3_stb = 1'b1; cpu_dout = 8'hC7;
      @(negedge clk); t3_stb = 1'b0; cpu_dout = 8'h00;
      chk("R6 write data on bus", {24'd0, bus_dout}, 32'hC7);
      back("write");
   endtask

   task automatic test_read_miss();
      // R3 type 01 data read at 0x2A55, outside window
      front(2'b01, 14'h2A55, 6'b111000);
      chk("R2 read address", {18'd0, bus_addr}, 32'h2A55);
      @(negedge clk); t3_stb = 1'b1; bus_din = 8'h5E; rom_din = 8'hA1;
      #1 chk("R7 read strobe in T3", {31'd0, rd_strobe}, 32'd1);
      @(negedge clk); t3_stb = 1'b0; bus_din = 8'h00;
      chk("R7 bus data to processor", {24'd0, cpu_din}, 32'h5E);
      back("read");
   endtask

   task automatic test_rom_fetch();
      // R3 type 00 fetch at 0x0210, window hit
      rom_din = 8'h3C; bus_din = 8'h99;
      front(2'b00, 14'h0210, 6'b000001);
      chk("R8 ROM data to processor", {24'd0, cpu_din}, 32'h3C);
      @(negedge clk); t3_stb = 1'b1;
      #1 chk("R8 no read strobe", {31'd0, rd_strobe}, 32'd0);
      @(negedge clk); t3_stb = 1'b0;
      chk("R8 bus still quiet", {18'd0, bus_addr}, 32'd0);
      back("fetch");
   endtask

   task automatic test_io();
      // R3 type 10 I/O at 0x0307, inside window yet on bus (R10)
      front(2'b10, 14'h0307, 6'b110010);
      chk("R9 R10 I/O address on bus", {18'd0, bus_addr}, 32'h0307);
      @(negedge clk); t3_stb = 1'b1; bus_din = 8'h6B;
      #1 chk("R9 strobe for I/O input", {31'd0, rd_strobe}, 32'd1);
      @(negedge clk); t3_stb = 1'b0;
      chk("R9 I/O data to processor", {24'd0, cpu_din}, 32'h6B);
      back("io");
   endtask

   initial begin
      test_reset();
      test_write();
      test_read_miss();
      test_rom_fetch();
      test_io();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule